// File: doc/BRIEF.md
# Memory Bus Decoder with ROM and Mirrored RAM Banks

This block sits on the memory side of an 8-bit processor bus. The bus has an address, an 8-bit data path, and active-low memory-request, read and write strobes. The top address bits split the space into eight equal windows, and each window has its own active-low select line. A select asserts only while the memory request is low.

A 2-to-4 decoder forms the read and write strobes. The memory request enables the decoder, and the read and write lines drive its two select inputs. Window 0 holds a read-only bank that fills the whole window. Window 4 holds a smaller read/write bank whose upper window offset bits are don't-care, so its contents repeat across the window. Reads from any other window return FFH.

The data bus is split into a write-data input and a read-data output. Read data is combinational: it is valid in the same cycle that the read strobe and a fitted window are active. Writes take effect on the rising clock edge. A test-mode preload port fills the read-only bank.

Top module: `memBusDecoder`

## Requirements
- R1: After reset `protoErr` is 0. With `mreqN` high, every bit of `bankSelN` is 1, both `memRdN` and `memWrN` are 1, `rdData` is FFH and `rdValid` is 0.
- R2: While `mreqN` is low, exactly one bit of `bankSelN` is low. That bit is bit k, where k is the value of the top SEL_W address bits. Each window spans 2^(ADDR_W-SEL_W) bytes.
- R3: While `mreqN` is high, no bank select asserts, whatever the address, `rdN` and `wrN` are.
- R4: The strobes are decoded from the code {rdN, wrN}, enabled by `mreqN` low. Code 01 drives `memRdN` low, code 10 drives `memWrN` low, and code 11 leaves both high. With `mreqN` high, both strobes stay high.
- R5: With `mreqN`, `rdN` and `wrN` all low, neither strobe asserts and no bank is written. `protoErr` rises at the next clock edge and stays high until reset.
- R6: A read of window 0 returns the read-only byte at window offset addr[ADDR_W-SEL_W-1:0], with `rdValid` high in the same cycle.
- R7: A bus write to window 0 leaves the read-only contents unchanged.
- R8: A bus write to window 4 stores `wrData` at the rising edge. A later read at the same address returns it with `rdValid` high.
- R9: The read/write bank is indexed by addr[RAM_AW-1:0] only. A write through any mirror image in window 4 is read back at the same low offset through every other image.
- R10: A read of a window other than 0 or 4 returns FFH with `rdValid` low.
- R11: The preload port writes `preData` at `preAddr` on the rising edge only while `testMode` and `preWe` are both high. With `testMode` low, it has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| mreqN | input | 1 | Active-low memory request |
| rdN | input | 1 | Active-low read |
| wrN | input | 1 | Active-low write |
| addr | input | ADDR_W | Bus address |
| wrData | input | 8 | Write data from the processor |
| rdData | output | 8 | Read data to the processor, FFH when nothing drives it |
| rdValid | output | 1 | High while a fitted bank supplies `rdData` |
| bankSelN | output | 2^SEL_W | Active-low window selects |
| memRdN | output | 1 | Active-low decoded memory read strobe |
| memWrN | output | 1 | Active-low decoded memory write strobe |
| protoErr | output | 1 | Sticky flag for read and write both low |
| testMode | input | 1 | Enables the preload port |
| preWe | input | 1 | Preload write enable |
| preAddr | input | ADDR_W-SEL_W | Preload address in the read-only bank |
| preData | input | 8 | Preload data |

## Verification
The bench builds the block with ADDR_W=14, SEL_W=3 and RAM_AW=9. This gives 2 KB windows, a 2 KB read-only bank and a 512-byte read/write bank that repeats four times in window 4, at 2000H, 2200H, 2400H and 2600H. These sizes keep the arrays small while keeping the same ratios as a full 16-bit map with an 8 KB ROM and a 2 KB RAM. Every window, every mirror image and the last byte of each bank can therefore be reached in a few directed cycles.

// File: rtl/memBusPkg.sv
package memBusPkg;
  typedef struct packed {
    logic rd;      // decoded read strobe, active high
    logic wr;      // decoded write strobe, active high
    logic romSel;  // read-only window selected
    logic ramSel;  // read/write window selected
  } memStrobe_t;
endpackage

// File: rtl/memBusCtrl.sv
module memBusCtrl
  import memBusPkg::*;
#(
  parameter int SEL_W   = 3,
  parameter int ROM_SEL = 0,
  parameter int RAM_SEL = 4,
  localparam int NSEL   = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             mreqN,
  input  logic             rdN,
  input  logic             wrN,
  input  logic [SEL_W-1:0] selBits,
  output logic [NSEL-1:0]  bankSelN,
  output logic             memRdN,
  output logic             memWrN,
  output logic             protoErr,
  output memStrobe_t       strobe
);
  logic [3:0]      decOut;
  logic [NSEL-1:0] selHot;

  // 2-to-4 decoder, enabled by the request, select code {rdN, wrN}
  always_comb begin
    decOut = '0;
    if (!mreqN) decOut[{rdN, wrN}] = 1'b1;
  end

  assign memRdN = ~decOut[1];
  assign memWrN = ~decOut[2];

  for (genvar g = 0; g < NSEL; g++) begin : g_win
    assign selHot[g]   = !mreqN && (selBits == SEL_W'(g));
    assign bankSelN[g] = ~selHot[g];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          protoErr <= 1'b0;
    else if (decOut[0]) protoErr <= 1'b1;
  end

  always_comb begin
    strobe.rd     = decOut[1];
    strobe.wr     = decOut[2];
    strobe.romSel = selHot[ROM_SEL];
    strobe.ramSel = selHot[RAM_SEL];
  end
endmodule

// File: rtl/memBusData.sv
module memBusData
  import memBusPkg::*;
#(
  parameter int WIN_AW = 11,
  parameter int RAM_AW = 9,
  localparam int ROM_DEPTH = 1 << WIN_AW,
  localparam int RAM_DEPTH = 1 << RAM_AW
) (
  input  logic              clk,
  input  memStrobe_t        strobe,
  input  logic [WIN_AW-1:0] winAddr,
  input  logic [7:0]        wrData,
  input  logic              testMode,
  input  logic              preWe,
  input  logic [WIN_AW-1:0] preAddr,
  input  logic [7:0]        preData,
  output logic [7:0]        rdData,
  output logic              rdValid
);
  logic [7:0]        romMem [ROM_DEPTH];
  logic [7:0]        ramMem [RAM_DEPTH];
  logic [RAM_AW-1:0] ramIdx;

  // upper offset bits are don't-care for the smaller bank
  assign ramIdx = winAddr[RAM_AW-1:0];

  always_ff @(posedge clk) begin
    if (testMode && preWe) romMem[preAddr] <= preData;
  end

  always_ff @(posedge clk) begin
    if (strobe.wr && strobe.ramSel) ramMem[ramIdx] <= wrData;
  end

  always_comb begin
    rdData  = 8'hFF;
    rdValid = 1'b0;
    if (strobe.rd) begin
      if (strobe.romSel) begin
        rdData  = romMem[winAddr];
        rdValid = 1'b1;
      end else if (strobe.ramSel) begin
        rdData  = ramMem[ramIdx];
        rdValid = 1'b1;
      end
    end
  end
endmodule

// File: rtl/memBusDecoder.sv
module memBusDecoder
  import memBusPkg::*;
#(
  parameter int ADDR_W  = 14,
  parameter int SEL_W   = 3,
  parameter int RAM_AW  = 9,
  parameter int ROM_SEL = 0,
  parameter int RAM_SEL = 4,
  localparam int WIN_AW = ADDR_W - SEL_W,
  localparam int NSEL   = 1 << SEL_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              mreqN,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  output logic              rdValid,
  output logic [NSEL-1:0]   bankSelN,
  output logic              memRdN,
  output logic              memWrN,
  output logic              protoErr,
  input  logic              testMode,
  input  logic              preWe,
  input  logic [WIN_AW-1:0] preAddr,
  input  logic [7:0]        preData
);
  memStrobe_t strobe;

  memBusCtrl #(.SEL_W(SEL_W), .ROM_SEL(ROM_SEL), .RAM_SEL(RAM_SEL)) u_ctrl (
    .clk(clk), .rstN(rstN), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
    .selBits(addr[ADDR_W-1 -: SEL_W]), .bankSelN(bankSelN),
    .memRdN(memRdN), .memWrN(memWrN), .protoErr(protoErr), .strobe(strobe)
  );

  memBusData #(.WIN_AW(WIN_AW), .RAM_AW(RAM_AW)) u_data (
    .clk(clk), .strobe(strobe), .winAddr(addr[WIN_AW-1:0]), .wrData(wrData),
    .testMode(testMode), .preWe(preWe), .preAddr(preAddr), .preData(preData),
    .rdData(rdData), .rdValid(rdValid)
  );
endmodule

// File: rtl/memBusDecoder_chk.sv
module memBusDecoder_chk #(
  parameter int NSEL = 8
) (
  input logic            clk,
  input logic            rstN,
  input logic            mreqN,
  input logic            rdN,
  input logic            wrN,
  input logic [NSEL-1:0] bankSelN,
  input logic            memRdN,
  input logic            memWrN,
  input logic            protoErr,
  input logic            rdValid
);
  a_r2_one_select: assert property (@(posedge clk) disable iff (!rstN)
    !mreqN |-> $countones(~bankSelN) == 1);

  a_r3_idle_no_select: assert property (@(posedge clk) disable iff (!rstN)
    mreqN |-> &bankSelN);

  a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(!memRdN && !memWrN));

  a_r4_read_needs_request: assert property (@(posedge clk) disable iff (!rstN)
    !memRdN |-> (!mreqN && !rdN && wrN));

  a_r5_clash_sets_flag: assert property (@(posedge clk) disable iff (!rstN)
    (!mreqN && !rdN && !wrN) |=> protoErr);

  a_r5_flag_sticky: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);

  a_r10_valid_needs_read: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !memRdN);
endmodule

bind memBusDecoder memBusDecoder_chk #(.NSEL(NSEL)) u_chk (
  .clk(clk), .rstN(rstN), .mreqN(mreqN), .rdN(rdN), .wrN(wrN),
  .bankSelN(bankSelN), .memRdN(memRdN), .memWrN(memWrN),
  .protoErr(protoErr), .rdValid(rdValid)
);

// File: tb/tb_memBusDecoder.sv
`timescale 1ns/1ps
module tb_memBusDecoder;
  localparam int ADDR_W = 14;
  localparam int SEL_W  = 3;
  localparam int RAM_AW = 9;
  localparam int WIN_AW = ADDR_W - SEL_W;
  localparam int NSEL   = 1 << SEL_W;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mreqN = 1'b1, rdN = 1'b1, wrN = 1'b1;
  logic [ADDR_W-1:0] addr = '0;
  logic [7:0] wrData = '0;
  logic [7:0] rdData;
  logic rdValid;
  logic [NSEL-1:0] bankSelN;
  logic memRdN, memWrN, protoErr;
  logic testMode = 1'b0, preWe = 1'b0;
  logic [WIN_AW-1:0] preAddr = '0;
  logic [7:0] preData = '0;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  memBusDecoder #(.ADDR_W(ADDR_W), .SEL_W(SEL_W), .RAM_AW(RAM_AW)) dut (
    .clk(clk), .rstN(rstN), .mreqN(mreqN), .rdN(rdN), .wrN(wrN), .addr(addr),
    .wrData(wrData), .rdData(rdData), .rdValid(rdValid), .bankSelN(bankSelN),
    .memRdN(memRdN), .memWrN(memWrN), .protoErr(protoErr), .testMode(testMode),
    .preWe(preWe), .preAddr(preAddr), .preData(preData)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    mreqN = 1'b1; rdN = 1'b1; wrN = 1'b1; preWe = 1'b0;
  endtask

  task automatic busWrite(input logic [ADDR_W-1:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; mreqN = 1'b0; wrN = 1'b0; rdN = 1'b1;
    #2;
    chk(memWrN == 1'b0 && memRdN == 1'b1, "R4 write strobe", {memRdN, memWrN}, 2'b10);
    idle();
  endtask

  task automatic busRead(input logic [ADDR_W-1:0] a, input logic [7:0] expD,
                         input bit expV, input string tag);
    @(negedge clk);
    addr = a; mreqN = 1'b0; rdN = 1'b0; wrN = 1'b1;
    #2;
    chk(rdData == expD, tag, rdData, expD);
    chk(rdValid == expV, tag, rdValid, expV);
    idle();
  endtask

  task automatic preload(input bit tm, input logic [WIN_AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    testMode = tm; preWe = 1'b1; preAddr = a; preData = d;
    @(negedge clk);
    preWe = 1'b0; testMode = 1'b0;
  endtask

  task automatic testReset();
    #2;
    chk(protoErr == 1'b0, "R1 protoErr", protoErr, 0);
    chk(&bankSelN, "R1 selects idle", bankSelN, '1);
    chk(memRdN && memWrN, "R1 strobes idle", {memRdN, memWrN}, 2'b11);
    chk(rdData == 8'hFF && !rdValid, "R1 read bus idle", {rdValid, rdData}, 9'h0FF);
  endtask

  task automatic testBankDecode();
    for (int k = 0; k < NSEL; k++) begin
      @(negedge clk);
      addr = ADDR_W'((k << WIN_AW) | 'h1A5); mreqN = 1'b0; rdN = 1'b1; wrN = 1'b1;
      #2;
      chk(bankSelN == ~(NSEL'(1) << k), "R2 window select", bankSelN, ~(NSEL'(1) << k));
      mreqN = 1'b1; rdN = 1'b0;
      #2;
      chk(&bankSelN, "R3 no select without request", bankSelN, '1);
    end
    idle();
  endtask

  task automatic testStrobes();
    @(negedge clk);
    addr = '0; mreqN = 1'b0; rdN = 1'b0; wrN = 1'b1;
    #2; chk(!memRdN && memWrN, "R4 read code 01", {memRdN, memWrN}, 2'b01);
    rdN = 1'b1; wrN = 1'b0;
    #2; chk(memRdN && !memWrN, "R4 write code 10", {memRdN, memWrN}, 2'b10);
    wrN = 1'b1;
    #2; chk(memRdN && memWrN, "R4 code 11 idle", {memRdN, memWrN}, 2'b11);
    mreqN = 1'b1; rdN = 1'b0;
    #2; chk(memRdN && memWrN, "R4 no request", {memRdN, memWrN}, 2'b11);
    idle();
  endtask

  task automatic testRom();
    preload(1'b1, 11'h010, 8'hA5);
    preload(1'b1, 11'h7FF, 8'h3C);
    busRead(14'h0010, 8'hA5, 1'b1, "R6 rom read");
    busRead(14'h07FF, 8'h3C, 1'b1, "R6 rom last byte");
    preload(1'b0, 11'h010, 8'h77);
    busRead(14'h0010, 8'hA5, 1'b1, "R11 preload without test mode");
    busWrite(14'h0010, 8'h11);
    busRead(14'h0010, 8'hA5, 1'b1, "R7 rom write ignored");
  endtask

  task automatic testRam();
    busWrite(14'h2005, 8'h5A);
    busRead(14'h2005, 8'h5A, 1'b1, "R8 ram readback");
    busRead(14'h2205, 8'h5A, 1'b1, "R9 mirror 1");
    busRead(14'h2405, 8'h5A, 1'b1, "R9 mirror 2");
    busRead(14'h2605, 8'h5A, 1'b1, "R9 mirror 3");
    busWrite(14'h27FF, 8'hC3);
    busRead(14'h21FF, 8'hC3, 1'b1, "R9 write via top mirror");
  endtask

  task automatic testUnfitted();
    busRead(14'h2800, 8'hFF, 1'b0, "R10 window 5");
    busRead(14'h3FFF, 8'hFF, 1'b0, "R10 window 7");
    busRead(14'h0A00, 8'hFF, 1'b0, "R10 window 1");
  endtask

  task automatic testClash();
    chk(protoErr == 1'b0, "R5 flag clear before clash", protoErr, 0);
    @(negedge clk);
    addr = 14'h2005; wrData = 8'h00; mreqN = 1'b0; rdN = 1'b0; wrN = 1'b0;
    #2;
    chk(memRdN && memWrN, "R5 no strobe on clash", {memRdN, memWrN}, 2'b11);
    idle();
    #2; chk(protoErr == 1'b1, "R5 flag set", protoErr, 1);
    repeat (3) @(negedge clk);
    #2; chk(protoErr == 1'b1, "R5 flag sticky", protoErr, 1);
    busRead(14'h2005, 8'h5A, 1'b1, "R5 clash does not write");
  endtask

  initial begin
    fork
      begin
        #3;
        testReset();
        repeat (2) @(negedge clk);
        rstN = 1'b1;
        testBankDecode();
        testStrobes();
        testRom();
        testRam();
        testUnfitted();
        testClash();
      end
      begin
        #100000;
        chk(1'b0, "watchdog", 0, 1);
      end
    join_any
    disable fork;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule